// File: doc/BRIEF.md
# Serial Shift and Rotate Unit with Carry

This unit moves an 8-bit or 16-bit operand by a variable number of bit positions, one position per clock, and reports the final value along with a carry flag. The flag holds the last bit that left the operand. Seven operations are available: plain rotates in either direction, rotates in either direction that pass through the carry, an arithmetic right shift, and logical shifts in either direction. An eighth code leaves both the operand and the carry untouched.

An operation starts with a one-cycle `start` strobe. On that strobe the unit captures the operand, count, width select, operation code and incoming carry. It then runs one step per cycle for `count` cycles and raises `done` for a single cycle. When `done` is high, `result` and `carry_out` hold the final values. Both outputs keep those values until the next accepted start.

A byte operation takes its most significant bit from bit 7. It ignores operand bits 15:8 and drives them as zero on the result. A word operation uses bit 15 as its most significant bit.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation code 0 (plain rotate left): on each step the old most significant bit moves into bit 0, and the carry takes that same bit.
- R2: Operation code 1 (plain rotate right): on each step the old bit 0 moves into the most significant position, and the carry takes that same bit.
- R3: Operation code 2 (rotate left through carry): on each step the old carry enters bit 0, and the old most significant bit becomes the carry.
- R4: Operation code 3 (rotate right through carry): on each step the old carry enters the most significant position, and the old bit 0 becomes the carry. A byte operation with a count of 9 returns the starting operand and carry.
- R5: Operation code 4 (arithmetic shift right): on each step the most significant bit keeps its value, and the bit leaving position 0 goes to the carry.
- R6: Operation code 5 (shift left) fills bit 0 with zero and sends the departing most significant bit to the carry. Operation code 6 (shift right) fills the most significant position with zero and sends the departing bit 0 to the carry.
- R7: When `wide` is 0, the most significant position is bit 7, operand bits 15:8 have no effect, and result bits 15:8 read zero. When `wide` is 1, the most significant position is bit 15.
- R8: With a count of zero, `done` is high in the cycle right after the start edge, `result` equals the operand truncated to the selected width, and `carry_out` equals `carry_in`.
- R9: With a count of N, `done` first rises after N+1 clock edges, counting the start edge as the first. It stays high for exactly one cycle.
- R10: A `start` strobe that arrives while an operation is in progress has no effect. The running operation finishes with its own result and on its own schedule.
- R11: Operation code 7 leaves the value and the carry unchanged on every step and still takes `count` steps.
- R12: While `rst_n` is low, and after it is released, `result` is 0, `carry_out` is 0 and `done` is 0.
- R13: Outside an accepted start and an active step, `result` and `carry_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe. Accepted only when no operation is running |
| op | input | 3 | Operation code (0 to 7, see requirements) |
| wide | input | 1 | 1 selects 16-bit, 0 selects 8-bit |
| operand | input | 16 | Value to shift or rotate |
| count | input | CNT_W (5) | Number of single-bit steps |
| carry_in | input | 1 | Incoming carry flag |
| result | output | 16 | Shifted or rotated value |
| carry_out | output | 1 | Final carry flag |
| done | output | 1 | One-cycle pulse marking a finished operation |

## Verification
A wrong fill source or carry tap corrupts the result in the very next cycle after the faulty step. The damage then spreads one position per step, so the final value at `done` differs from the expected value for almost any operand pattern. A corrupt step counter shows up only at `done`: the pulse comes early or late against the N+1 edge schedule, or never comes. A stale width or operation register shows up as nonzero upper result bits in byte mode, or as the wrong operation's carry. Rotations through carry over nine bits, and sixteen plain rotations, bring a correct unit back to its start value. That makes one step dropped or added anywhere in the chain visible in the final value.

// File: rtl/sru_pkg.sv
`timescale 1ns/1ps
package sru_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int HIGH_W = WORD_W - BYTE_W;

  typedef enum logic [2:0] {
    OP_ROL  = 3'd0,
    OP_ROR  = 3'd1,
    OP_RLC  = 3'd2,
    OP_RRC  = 3'd3,
    OP_SAR  = 3'd4,
    OP_SHL  = 3'd5,
    OP_SHR  = 3'd6,
    OP_HOLD = 3'd7
  } sru_op_e;

  // Mask that keeps only the bits of the selected width.
  function automatic logic [WORD_W-1:0] width_mask(input logic wide);
    return wide ? {WORD_W{1'b1}} : {{HIGH_W{1'b0}}, {BYTE_W{1'b1}}};
  endfunction

  // Most significant bit of the active width.
  function automatic logic top_bit(input logic [WORD_W-1:0] v, input logic wide);
    return wide ? v[WORD_W-1] : v[BYTE_W-1];
  endfunction

  // Operations that move bits toward the most significant position.
  function automatic logic moves_left(input sru_op_e op);
    return (op == OP_ROL) || (op == OP_RLC) || (op == OP_SHL);
  endfunction

endpackage

// File: rtl/sru_step.sv
`timescale 1ns/1ps
module sru_step
  import sru_pkg::*;
(
  input  logic [WORD_W-1:0] val_i,
  input  logic              wide_i,
  input  sru_op_e           op_i,
  input  logic              cy_i,
  output logic [WORD_W-1:0] val_o,
  output logic              cy_o
);

  logic              msb;
  logic              lsb;
  logic              fill_lo;
  logic              fill_hi;
  logic [WORD_W-1:0] left_v;
  logic [WORD_W-1:0] right_v;

  always_comb begin
    msb = top_bit(val_i, wide_i);
    lsb = val_i[0];
    unique case (op_i)
      OP_ROL:  fill_lo = msb;
      OP_RLC:  fill_lo = cy_i;
      default: fill_lo = 1'b0;
    endcase
    unique case (op_i)
      OP_ROR:  fill_hi = lsb;
      OP_RRC:  fill_hi = cy_i;
      OP_SAR:  fill_hi = msb;
      default: fill_hi = 1'b0;
    endcase
  end

  // Per-bit source selection for both directions.
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign left_v[i] = fill_lo;
    end else begin : g_lo_mid
      assign left_v[i] = val_i[i-1];
    end
    if (i == WORD_W - 1) begin : g_hi
      assign right_v[i] = fill_hi;
    end else if (i == BYTE_W - 1) begin : g_hi_byte
      assign right_v[i] = wide_i ? val_i[i+1] : fill_hi;
    end else begin : g_hi_mid
      assign right_v[i] = val_i[i+1];
    end
  end

  always_comb begin
    if (op_i == OP_HOLD) begin
      val_o = val_i;
      cy_o  = cy_i;
    end else if (moves_left(op_i)) begin
      val_o = left_v & width_mask(wide_i);
      cy_o  = msb;
    end else begin
      val_o = right_v & width_mask(wide_i);
      cy_o  = lsb;
    end
  end

endmodule

// File: rtl/sru_ctrl.sv
`timescale 1ns/1ps
module sru_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             load_o,
  output logic             step_o,
  output logic             last_o,
  output logic             running_o,
  output logic             done_o
);

  logic             running_q;
  logic             done_q;
  logic [CNT_W-1:0] left_q;

  assign load_o    = start_i && !running_q;
  assign step_o    = running_q;
  assign last_o    = running_q && (left_q == CNT_W'(1));
  assign running_o = running_q;
  assign done_o    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
      left_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        if (count_i == '0) begin
          done_q <= 1'b1;
        end else begin
          running_q <= 1'b1;
          left_q    <= count_i;
        end
      end else if (step_o) begin
        left_q <= left_q - CNT_W'(1);
        if (last_o) begin
          running_q <= 1'b0;
          done_q    <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/shift_rotate_unit.sv
`timescale 1ns/1ps
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic             wide,
  input  logic [15:0]      operand,
  input  logic [CNT_W-1:0] count,
  input  logic             carry_in,
  output logic [15:0]      result,
  output logic             carry_out,
  output logic             done
);

  logic              load_fire;
  logic              step_fire;
  logic              last_step;
  logic              running;
  logic [WORD_W-1:0] val_q;
  logic              cy_q;
  sru_op_e           op_q;
  logic              wide_q;
  logic [WORD_W-1:0] step_val;
  logic              step_cy;

  sru_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .count_i   (count),
    .load_o    (load_fire),
    .step_o    (step_fire),
    .last_o    (last_step),
    .running_o (running),
    .done_o    (done)
  );

  sru_step u_step (
    .val_i  (val_q),
    .wide_i (wide_q),
    .op_i   (op_q),
    .cy_i   (cy_q),
    .val_o  (step_val),
    .cy_o   (step_cy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q  <= '0;
      cy_q   <= 1'b0;
      op_q   <= OP_HOLD;
      wide_q <= 1'b0;
    end else if (load_fire) begin
      val_q  <= operand & width_mask(wide);
      cy_q   <= carry_in;
      op_q   <= sru_op_e'(op);
      wide_q <= wide;
    end else if (step_fire) begin
      val_q <= step_val;
      cy_q  <= step_cy;
    end
  end

  assign result    = val_q;
  assign carry_out = cy_q;

endmodule

// File: rtl/sru_chk.sv
`timescale 1ns/1ps
module sru_chk
  import sru_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] count,
  input logic             carry_in,
  input logic [15:0]      result,
  input logic             carry_out,
  input logic             done,
  input logic             load_fire,
  input logic             step_fire,
  input logic             last_step,
  input logic             running,
  input sru_op_e          op_q,
  input logic             wide_q
);

  // R1
  rol_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && op_q == OP_ROL |=> carry_out == result[0]);

  // R3
  rlc_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && op_q == OP_RLC |=> result[0] == $past(carry_out));

  // R5
  sar_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && op_q == OP_SAR && wide_q |=> result[15] == $past(result[15]));

  // R6
  shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && op_q == OP_SHL |=> result[0] == 1'b0);

  // R7
  byte_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> result[15:8] == 8'h00);

  // R8
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire && count == '0 |=> done && carry_out == $past(carry_in));

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> done && !running);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && running && !last_step |=> running && !done);

  // R11
  hold_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && op_q == OP_HOLD |=> $stable(result) && $stable(carry_out));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_fire && !load_fire |=> $stable(result) && $stable(carry_out));

endmodule

bind shift_rotate_unit sru_chk #(.CNT_W(CNT_W)) u_sru_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .count     (count),
  .carry_in  (carry_in),
  .result    (result),
  .carry_out (carry_out),
  .done      (done),
  .load_fire (load_fire),
  .step_fire (step_fire),
  .last_step (last_step),
  .running   (running),
  .op_q      (op_q),
  .wide_q    (wide_q)
);

// File: tb/shift_rotate_unit_test.sv
`timescale 1ns/1ps
module shift_rotate_unit_test;

  localparam int CNT_W = 5;
  localparam int NV    = 19;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [2:0]       op = 3'd0;
  logic             wide = 1'b0;
  logic [15:0]      operand = 16'h0;
  logic [CNT_W-1:0] count = '0;
  logic             carry_in = 1'b0;
  logic [15:0]      result;
  logic             carry_out;
  logic             done;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  shift_rotate_unit #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
    .operand(operand), .count(count), .carry_in(carry_in),
    .result(result), .carry_out(carry_out), .done(done)
  );

  // {op[3], wide, operand[16], count[5], carry_in, exp_result[16], exp_carry}
  localparam logic [42:0] VEC [0:NV-1] = '{
    {3'd0, 1'b0, 16'h0081, 5'd1,  1'b0, 16'h0003, 1'b1}, // R1 byte rol
    {3'd0, 1'b1, 16'h1234, 5'd4,  1'b0, 16'h2341, 1'b1}, // R1 word rol
    {3'd1, 1'b0, 16'h0001, 5'd1,  1'b0, 16'h0080, 1'b1}, // R2 byte ror
    {3'd1, 1'b1, 16'h0001, 5'd16, 1'b1, 16'h0001, 1'b0}, // R2 full turn
    {3'd2, 1'b0, 16'h0080, 5'd1,  1'b1, 16'h0001, 1'b1}, // R3 byte rlc
    {3'd2, 1'b1, 16'h8000, 5'd2,  1'b0, 16'h0001, 1'b0}, // R3 chain
    {3'd3, 1'b1, 16'h0001, 5'd2,  1'b0, 16'h8000, 1'b0}, // R4 chain
    {3'd3, 1'b0, 16'h0000, 5'd9,  1'b1, 16'h0000, 1'b1}, // R4 nine-bit turn
    {3'd4, 1'b0, 16'h0080, 5'd3,  1'b0, 16'h00F0, 1'b0}, // R5 byte sar
    {3'd4, 1'b1, 16'h8001, 5'd1,  1'b0, 16'hC000, 1'b1}, // R5 word sar
    {3'd5, 1'b1, 16'h8001, 5'd1,  1'b0, 16'h0002, 1'b1}, // R6 word shl
    {3'd5, 1'b0, 16'h000F, 5'd4,  1'b1, 16'h00F0, 1'b0}, // R6 byte shl
    {3'd6, 1'b1, 16'h0003, 5'd2,  1'b0, 16'h0000, 1'b1}, // R6 word shr
    {3'd6, 1'b0, 16'hFF80, 5'd1,  1'b1, 16'h0040, 1'b0}, // R7 upper ignored
    {3'd0, 1'b0, 16'hAA80, 5'd1,  1'b0, 16'h0001, 1'b1}, // R7 msb is bit 7
    {3'd0, 1'b0, 16'h00AB, 5'd0,  1'b1, 16'h00AB, 1'b1}, // R8 zero count
    {3'd6, 1'b1, 16'hBEEF, 5'd0,  1'b0, 16'hBEEF, 1'b0}, // R8 zero count word
    {3'd7, 1'b1, 16'h1357, 5'd3,  1'b1, 16'h1357, 1'b1}, // R11 hold code
    {3'd4, 1'b0, 16'h12C4, 5'd0,  1'b0, 16'h00C4, 1'b0}  // R8 zero count truncates
  };

  function automatic string vtag(input int i);
    case (i)
      0, 1:           return "R1";
      2, 3:           return "R2";
      4, 5:           return "R3";
      6, 7:           return "R4";
      8, 9:           return "R5";
      10, 11, 12:     return "R6";
      13, 14:         return "R7";
      17:             return "R11";
      default:        return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic w, input logic [15:0] v,
                     input logic [CNT_W-1:0] n, input logic ci,
                     output int edges, output logic [15:0] r, output logic c);
    @(negedge clk);
    op = o; wide = w; operand = v; count = n; carry_in = ci; start = 1'b1;
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && edges < 100) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
    r = result;
    c = carry_out;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int          edges;
    logic [15:0] r;
    logic        c;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: state held in reset
    chk("R12", {result, carry_out, done}, 18'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", {result, carry_out, done}, 18'h0);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][42:40], VEC[i][39], VEC[i][38:23], VEC[i][22:18], VEC[i][17],
          edges, r, c);
      chk(vtag(i), r, VEC[i][16:1]);
      chk(vtag(i), c, VEC[i][0]);
      // R9: done after count+1 edges
      chk("R9", edges, 32'(VEC[i][22:18]) + 1);
      @(negedge clk);
      // R9: single-cycle pulse
      chk("R9", done, 1'b0);
    end

    // R10: start during a run is ignored
    @(negedge clk);
    op = 3'd0; wide = 1'b1; operand = 16'h0001; count = 5'd6; carry_in = 1'b0; start = 1'b1;
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    start = 1'b0;
    @(posedge clk); edges++;
    @(negedge clk);
    op = 3'd6; operand = 16'hFFFF; count = 5'd1; carry_in = 1'b1; start = 1'b1;
    @(posedge clk); edges++;
    @(negedge clk);
    start = 1'b0;
    chk("R10", done, 1'b0);
    while (!done && edges < 100) begin
      @(posedge clk); edges++;
      @(negedge clk);
    end
    chk("R10", edges, 7);
    chk("R10", result, 16'h0040);
    chk("R10", carry_out, 1'b0);

    // R13: outputs hold while idle
    repeat (5) @(negedge clk);
    chk("R13", {result, carry_out}, {16'h0040, 1'b0});

    // R12: reset in the middle of a run
    run(3'd0, 1'b1, 16'h00FF, 5'd0, 1'b1, edges, r, c);
    @(negedge clk);
    op = 3'd5; operand = 16'h7777; count = 5'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12", {result, carry_out, done}, 18'h0);
    rst_n = 1'b1;
    repeat (25) @(negedge clk);
    chk("R12", {result, carry_out, done}, 18'h0);

    // R4: chained byte rotate through carry after reset
    run(3'd3, 1'b0, 16'h0001, 5'd1, 1'b0, edges, r, c);
    chk("R4", {r, c}, {16'h0000, 1'b1});

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule